// File: doc/BRIEF.md
# Staged Multi-Domain Reset Sequencer

This block generates the resets of a high-speed serial converter link subsystem and releases them in a fixed order. It drives five reset outputs: the core clock generator, the transceiver PHY (fed to a separate PHY reset controller), the link control/status registers, the link layer, and the frame domain. A sequence starts from the global reset pin or from a soft-reset write on a small memory-mapped register port. Either trigger asserts all five outputs together. The outputs are then released one stage at a time.

Each stage is held for a programmable hold-off. It is released only once its gating condition holds. The clock-generator stage has no gate. The PHY stage waits for the core clock lock indication, and a timeout counter releases it if lock never comes. The three link-side stages wait for the transceiver ready indication. A status register reports the current stage, a completion flag and a sticky timeout flag.

Top module: `rst_chain_seq`

## Requirements
- R1: `rst_out` bit 0 is the clock-generator reset, bit 1 the PHY reset, bit 2 the link register reset, bit 3 the link-layer reset and bit 4 the frame reset (active high). All five are high while a hard reset is active, and from the clock edge that accepts a soft-reset write. All are low once the sequence completes.
- R2: Raising `por_in` drives all outputs high at once, without a clock edge. Its fall passes through a two-flop synchronizer, so the sequencer is held in its first stage through the second clock edge after the fall and starts counting at the third.
- R3: A write to address 0x0 with data bit 0 set starts a sequence. A write there with bit 0 clear has no effect. Address 0x0 always reads as zero.
- R4: Stages are released strictly in index order, at most one per clock edge. A stage is never released while a lower-index stage is still held.
- R5: On entering a stage the cycle counter restarts from zero. The stage is released on the first edge at which the counter has reached the hold-off H and the stage's gate holds. With gates already true, stage k is released H+1 edges after stage k-1. H is held at address 0x8 bits [15:0], and is restored to 16 by a hard reset.
- R6: Stage 0 has no gate. Stage 1 is gated by `pll_locked` through a two-flop synchronizer: a rise before edge a is first honoured at edge a+2.
- R7: If stage 1 has not been released when its counter reaches TIMEOUT_CYC, it is released on that edge and the timeout flag (status bit 9) is set. The flag stays set until the next trigger clears it.
- R8: Stages 2, 3 and 4 are gated by `xcvr_ready`, which is synchronized with the same two-edge latency. These stages have no timeout.
- R9: Address 0x4 reads the status: bits [2:0] give the current stage index (5 when complete) and bit 8 the completion flag.
- R10: A trigger arriving mid-sequence reasserts all outputs on that edge and restarts from stage 0 with a fresh count.
- R11: Writes to 0x4 and to unmapped addresses change nothing, and unmapped addresses read zero. A hold-off write larger than the field's maximum saturates to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_in | input | 1 | Hard reset from the global reset pin, active high, asynchronous |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| pll_locked | input | 1 | Core clock generator lock indication, asynchronous |
| xcvr_ready | input | 1 | Transceiver ready from the PHY reset controller, asynchronous |
| rst_out | output | 5 | Stage resets, bit order as in R1 |

## Verification
The bench builds the block with TIMEOUT_CYC at 40 and leaves the other parameters at their defaults. The lock timeout therefore expires after a few dozen cycles instead of a thousand. The hold-off is reprogrammed at run time to 0, 2, 4, 5 and 16. This covers back-to-back releases, releases governed purely by the hold-off, and releases governed by a late gate. Lock and ready are raised at chosen edges, so the two-edge synchronizer latency can be seen in exact release edges. Restarts are exercised by soft triggers mid-sequence and by a hard pulse taken between clock edges.

// File: rtl/rst_chain_pkg.sv
package rst_chain_pkg;

    localparam int N_STAGE = 5;
    localparam int IDX_W   = $clog2(N_STAGE + 1);
    localparam int REG_W   = 32;

    // stage positions in the release order
    localparam int STG_CLKGEN = 0;
    localparam int STG_PHY    = 1;

    // register byte offsets
    localparam int OFF_CTRL = 'h0;
    localparam int OFF_STAT = 'h4;
    localparam int OFF_HOLD = 'h8;

    localparam int STAT_DONE_BIT = 8;
    localparam int STAT_TERR_BIT = 9;

    typedef enum logic [1:0] {
        GATE_NONE,
        GATE_LOCK,
        GATE_READY
    } gate_e;

    typedef struct packed {
        logic             terr;
        logic             done;
        logic [IDX_W-1:0] idx;
    } seq_stat_t;

    function automatic gate_e stage_gate(input logic [IDX_W-1:0] idx);
        if (idx == IDX_W'(STG_CLKGEN))
            return GATE_NONE;
        else if (idx == IDX_W'(STG_PHY))
            return GATE_LOCK;
        else
            return GATE_READY;
    endfunction

    function automatic logic [REG_W-1:0] pack_stat(input seq_stat_t s);
        logic [REG_W-1:0] r;
        r                = '0;
        r[IDX_W-1:0]     = s.idx;
        r[STAT_DONE_BIT] = s.done;
        r[STAT_TERR_BIT] = s.terr;
        return r;
    endfunction

endpackage

// File: rtl/rst_chain_sync.sv
module rst_chain_sync #(
    parameter int W         = 1,
    parameter bit ASYNC_SET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_in,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] s0;
    logic [W-1:0] s1;

    generate
        if (ASYNC_SET) begin : g_aset
            // asserts at once, releases through two flops
            always_ff @(posedge clk or posedge rst_in) begin
                if (rst_in) begin
                    s0 <= '1;
                    s1 <= '1;
                end else begin
                    s0 <= d;
                    s1 <= s0;
                end
            end

            // R2
            sync_release_chk: assert property (@(posedge clk) disable iff (rst_in)
                $fell(s1[0]) |-> !$past(rst_in, 2));
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst_in) begin
                    s0 <= '0;
                    s1 <= '0;
                end else begin
                    s0 <= d;
                    s1 <= s0;
                end
            end
        end
    endgenerate

    assign q = s1;

endmodule

// File: rtl/rst_chain_regs.sv
module rst_chain_regs
    import rst_chain_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int CNT_W        = 16,
    parameter int HOLD_DEFAULT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  seq_stat_t         stat,
    output logic [REG_W-1:0]  rdata,
    output logic [CNT_W-1:0]  holdoff,
    output logic              soft_trig
);

    logic sel_ctrl;
    logic sel_stat;
    logic sel_hold;
    logic [CNT_W-1:0] hold_wr;

    assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
    assign sel_stat = (addr == ADDR_W'(OFF_STAT));
    assign sel_hold = (addr == ADDR_W'(OFF_HOLD));

    // write-one pulse, never stored
    assign soft_trig = wen && sel_ctrl && wdata[0];

    // oversized hold-off values clamp to the field maximum
    assign hold_wr = (|wdata[REG_W-1:CNT_W]) ? '1 : wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            holdoff <= CNT_W'(HOLD_DEFAULT);
        else if (wen && sel_hold)
            holdoff <= hold_wr;
    end

    always_comb begin
        rdata = '0;
        if (sel_stat)
            rdata = pack_stat(stat);
        else if (sel_hold)
            rdata = REG_W'(holdoff);
    end

    // R11
    hold_ro_chk: assert property (@(posedge clk) disable iff (rst)
        !(wen && sel_hold) |=> $stable(holdoff));

endmodule

// File: rtl/rst_chain_fsm.sv
module rst_chain_fsm
    import rst_chain_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic               lock_s,
    input  logic               ready_s,
    input  logic [CNT_W-1:0]   holdoff,
    output logic [N_STAGE-1:0] stage_rst,
    output seq_stat_t          stat
);

    localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT_CYC);

    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             terr;

    gate_e gate;
    logic  active;
    logic  hold_met;
    logic  gate_ok;
    logic  norm_rel;
    logic  to_rel;

    assign gate     = stage_gate(idx);
    assign active   = (idx < IDX_W'(N_STAGE));
    assign hold_met = (cnt >= holdoff);

    always_comb begin
        case (gate)
            GATE_NONE: gate_ok = 1'b1;
            GATE_LOCK: gate_ok = lock_s;
            default:   gate_ok = ready_s;
        endcase
    end

    assign norm_rel = active && hold_met && gate_ok;
    assign to_rel   = active && (gate == GATE_LOCK) && !norm_rel && (cnt >= TO_LIM);

    always_ff @(posedge clk) begin
        if (rst || trig) begin
            idx  <= '0;
            cnt  <= '0;
            terr <= 1'b0;
        end else if (norm_rel || to_rel) begin
            idx <= idx + IDX_W'(1);
            cnt <= '0;
            if (to_rel)
                terr <= 1'b1;
        end else if (active && (cnt != '1)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    generate
        for (genvar k = 0; k < N_STAGE; k++) begin : g_out
            assign stage_rst[k] = (idx <= IDX_W'(k));
        end
    endgenerate

    assign stat.idx  = idx;
    assign stat.done = !active;
    assign stat.terr = terr;

    // R4
    one_release_chk: assert property (@(posedge clk) disable iff (rst)
        $countones($past(stage_rst) & ~stage_rst) <= 1);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones($past(stage_rst) & ~stage_rst) == 1) |->
            (($past(cnt) >= $past(holdoff)) || $rose(terr)));

    // R6
    lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stage_rst[STG_PHY]) |-> ($past(lock_s) || $rose(terr)));

    // R7
    timeout_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(terr) |-> (($past(cnt) >= TO_LIM) && !$past(lock_s)));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> ((&stage_rst) && (idx == '0)));

    generate
        for (genvar k = 1; k < N_STAGE; k++) begin : g_chk
            // R4
            order_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(stage_rst[k]) |-> !$past(stage_rst[k-1]));
            if (k > STG_PHY) begin : g_rdy
                // R8
                ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
                    $fell(stage_rst[k]) |-> $past(ready_s));
            end
        end
    endgenerate

endmodule

// File: rtl/rst_chain_seq.sv
module rst_chain_seq
    import rst_chain_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int CNT_W        = 16,
    parameter int TIMEOUT_CYC  = 1024,
    parameter int HOLD_DEFAULT = 16
) (
    input  logic               clk,
    input  logic               por_in,
    input  logic               reg_wen,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               pll_locked,
    input  logic               xcvr_ready,
    output logic [N_STAGE-1:0] rst_out
);

    logic               hard_q;
    logic [1:0]         stat_s;
    logic [CNT_W-1:0]   holdoff;
    logic               soft_trig;
    logic [N_STAGE-1:0] stage_rst;
    seq_stat_t          stat;

    rst_chain_sync #(.W(1), .ASYNC_SET(1'b1)) u_por_sync (
        .clk    (clk),
        .rst_in (por_in),
        .d      (1'b0),
        .q      (hard_q)
    );

    rst_chain_sync #(.W(2), .ASYNC_SET(1'b0)) u_stat_sync (
        .clk    (clk),
        .rst_in (hard_q),
        .d      ({xcvr_ready, pll_locked}),
        .q      (stat_s)
    );

    rst_chain_regs #(
        .ADDR_W       (ADDR_W),
        .CNT_W        (CNT_W),
        .HOLD_DEFAULT (HOLD_DEFAULT)
    ) u_regs (
        .clk       (clk),
        .rst       (hard_q),
        .wen       (reg_wen),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .stat      (stat),
        .rdata     (reg_rdata),
        .holdoff   (holdoff),
        .soft_trig (soft_trig)
    );

    rst_chain_fsm #(
        .CNT_W       (CNT_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (hard_q),
        .trig      (soft_trig),
        .lock_s    (stat_s[0]),
        .ready_s   (stat_s[1]),
        .holdoff   (holdoff),
        .stage_rst (stage_rst),
        .stat      (stat)
    );

    // hard reset overrides every stage without waiting for an edge
    assign rst_out = stage_rst | {N_STAGE{hard_q}};

endmodule

// File: tb/rst_chain_seq_tb_top.sv
module rst_chain_seq_tb_top;

    logic        clk = 1'b0;
    logic        por_in = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        pll_locked = 1'b1;
    logic        xcvr_ready = 1'b1;
    logic [4:0]  rst_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit fin      = 1'b0;
    int rel [5];

    always #10 clk = ~clk;

    rst_chain_seq #(.TIMEOUT_CYC(40)) dut_i (
        .clk        (clk),
        .por_in     (por_in),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pll_locked (pll_locked),
        .xcvr_ready (xcvr_ready),
        .rst_out    (rst_out)
    );

    // {hold-off, lock rise edge (0 = never), ready rise edge, release edges of stages 0..4, timeout flag}
    localparam int VEC [4][9] = '{
        '{16,  1,  1, 17, 34, 51, 68, 85, 0},
        '{ 2, 30, 50,  3, 32, 52, 55, 58, 0},
        '{ 0,  1,  1,  1,  3,  4,  5,  6, 0},
        '{ 5,  0,  1,  6, 47, 53, 59, 65, 1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // soft trigger accepted at the next rising edge; returns at the falling edge after it
    task automatic soft_fire(input bit drop_inputs);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1;
        if (drop_inputs) begin
            pll_locked = 1'b0;
            xcvr_ready = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = 32'h0;
    endtask

    // records, per stage, the first edge index at which its reset is seen low
    task automatic watch(input int lock_at, input int ready_at, input int ncyc);
        for (int k = 0; k < 5; k++) rel[k] = 0;
        for (int j = 1; j <= ncyc; j++) begin
            if (lock_at == j)  pll_locked = 1'b1;
            if (ready_at == j) xcvr_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            for (int k = 0; k < 5; k++)
                if (rel[k] == 0 && !rst_out[k]) rel[k] = j;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        #2 por_in = 1'b1;

        // reset state
        repeat (3) @(negedge clk);
        chk("R1 all resets high under hard reset", {27'h0, rst_out}, 32'h1F);
        rd(4'h4, d);
        chk("R9 status under hard reset", d, 32'h0);
        rd(4'h8, d);
        chk("R5 hold-off default", d, 32'd16);

        // hard release through the synchronizer
        por_in = 1'b0;
        watch(0, 0, 25);
        chk("R2 stage 0 release edge after por fall", rel[0], 19);
        repeat (100) @(negedge clk);
        chk("R1 all resets low when complete", {27'h0, rst_out}, 32'h0);
        rd(4'h4, d);
        chk("R9 status when complete", d, 32'h105);

        // table of gating scenarios
        for (int v = 0; v < 4; v++) begin
            pll_locked = 1'b1;
            xcvr_ready = 1'b1;
            wr(4'h8, VEC[v][0]);
            repeat (4) @(negedge clk);
            soft_fire(1'b1);
            watch(VEC[v][1], VEC[v][2], 100);
            for (int k = 0; k < 5; k++)
                chk($sformatf("R4/R5/R6/R8 vec %0d stage %0d release edge", v, k), rel[k], VEC[v][3+k]);
            rd(4'h4, d);
            chk($sformatf("R7/R9 vec %0d final status", v), d, 32'h105 | (VEC[v][8] << 9));
        end
        pll_locked = 1'b1;
        xcvr_ready = 1'b1;
        repeat (4) @(negedge clk);

        // control write with bit 0 clear
        wr(4'h0, 32'hFFFE);
        repeat (3) @(negedge clk);
        chk("R3 clear-bit write leaves resets released", {27'h0, rst_out}, 32'h0);
        rd(4'h0, d);
        chk("R3 control reads zero", d, 32'h0);

        // status and unmapped writes
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d);
        chk("R11 status write ignored", d, 32'h305);
        wr(4'hC, 32'h3);
        rd(4'hC, d);
        chk("R11 unmapped reads zero", d, 32'h0);
        rd(4'h8, d);
        chk("R11 unmapped write leaves hold-off", d, 32'd5);
        wr(4'h8, 32'h0001_0000);
        rd(4'h8, d);
        chk("R11 hold-off saturates", d, 32'hFFFF);

        // restart mid-sequence
        wr(4'h8, 32'd4);
        soft_fire(1'b0);
        watch(0, 0, 12);
        chk("R4 partial release after 12 edges", {27'h0, rst_out}, 32'h1C);
        rd(4'h4, d);
        chk("R9 stage index mid-sequence", d, 32'h2);
        soft_fire(1'b0);
        chk("R10 restart reasserts all", {27'h0, rst_out}, 32'h1F);
        rd(4'h4, d);
        chk("R7/R10 restart clears index and timeout flag", d, 32'h0);
        watch(0, 0, 6);
        chk("R10 stage 0 release after restart", rel[0], 5);

        // hard pulse between edges
        repeat (40) @(negedge clk);
        chk("R1 complete before hard pulse", {27'h0, rst_out}, 32'h0);
        por_in = 1'b1;
        #2;
        chk("R2 asynchronous assertion", {27'h0, rst_out}, 32'h1F);
        @(negedge clk);
        por_in = 1'b0;
        repeat (120) @(negedge clk);
        chk("R1 released after hard pulse", {27'h0, rst_out}, 32'h0);
        rd(4'h8, d);
        chk("R5 hard reset restores hold-off", d, 32'd16);

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule